// File: doc/BRIEF.md
# PLL Phase Resync Sync Timer

This timer runs on the phase-detector reference clock of a fractional-N synthesizer. It produces the periodic sync pulses used to realign the synthesizer's output phase with its input reference. Two programmable counts set the sync period, and the period is their product. The first count is a 12-bit clock-divider value. The second is the fractional modulus. In 16-bit extended modulus mode the modulus term is limited to 4095.

The serial programming port drives an active-low chip-select, and the timer watches it. Each rising edge of chip-select marks the end of a write. That edge restarts the timer from zero. The timer then ignores the first sync pulse that follows and raises a one-cycle resync strobe together with the second. Later pulses produce no further strobe until the next write ends. The timer also exports the running value of its inner divider counter, because the fast-lock timing function uses the same count.

All pins are plain control and status lines with no stream interface, so no valid/ready handshake or back-pressure applies. The configuration inputs are expected to stay stable while resync is enabled. Software normally writes them with the mode field set to something other than resync, or in the same write that ends with the chip-select rise.

Top module: `pll_resync_timer`

## Requirements
- R1: The timer runs only when `mode_sel` equals 2'b10 (upper bit 1, lower bit 0). For any other value it holds its counters in reset, and `sync_pulse` and `resync_strobe` stay low.
- R2: Let P be the clock-divider value times the effective modulus. When the timer restarts on a clock edge E, `sync_pulse` goes high for exactly one cycle after edges E+P, E+2P, E+3P and so on.
- R3: When `ext_mod` is 0, the modulus term is the low 12 bits of `modulus`, and bits 15:12 are ignored.
- R4: When `ext_mod` is 1, the modulus term is the smaller of `modulus` and 4095.
- R5: After a chip-select rise, the first sync pulse produces no strobe. `resync_strobe` is high for exactly one cycle, in the same cycle as the second sync pulse.
- R6: At most one strobe follows each chip-select rise, and no strobe occurs after reset until the first chip-select rise.
- R7: A rising edge on `cs_n` while enabled restarts the divider counter, the modulus counter and the pulse count on that clock edge, so later pulses are timed from that edge.
- R8: A clock-divider value of 0, or an effective modulus of 0, disables the timer. No sync pulse and no strobe occur.
- R9: `div_count` is 0 in the cycle after a restart. It then rises by one per reference clock and returns to 0 after reaching the clock-divider value minus one.
- R10: While `rst_n` is low, both pulse outputs and `div_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Phase-detector reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Timer mode field; 2'b10 selects resync |
| clk_div | input | 12 | Clock-divider count, 1 to 4095; 0 disables |
| modulus | input | 16 | Fractional modulus value |
| ext_mod | input | 1 | Extended 16-bit modulus mode |
| cs_n | input | 1 | Active-low chip-select of the programming port |
| sync_pulse | output | 1 | One-cycle periodic sync pulse |
| resync_strobe | output | 1 | One-cycle resync strobe, once per write |
| div_count | output | 12 | Running inner divider count, for fast-lock reuse |

## Verification
Some rules are checked by assertions on every cycle:
- Both outputs stay quiet when the mode field is not resync or the divider is zero.
- The strobe only ever coincides with a sync pulse and is one cycle wide.
- A chip-select rise zeroes the divider count on the next cycle.
- No strobe appears directly after a chip-select rise.

Other behaviour can only be shown by the bench's scenarios:
- The exact cycle of each pulse as the product of the two counts.
- Truncation of the modulus in normal mode and clamping in extended mode.
- Suppression of the first pulse and of every pulse after the second.
- Restart of the timing when a second write ends in mid-period.

// File: rtl/pll_resync_pkg.sv
package pll_resync_pkg;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned MOD_W = 16;
  localparam int unsigned PC_W  = 2;

  typedef enum logic [1:0] {
    TMR_OFF0   = 2'b00,
    TMR_OFF1   = 2'b01,
    TMR_RESYNC = 2'b10,
    TMR_OFF3   = 2'b11
  } tmr_mode_e;

  typedef enum logic [PC_W-1:0] {
    PC_NONE = 2'd0,
    PC_ONE  = 2'd1,
    PC_DONE = 2'd2
  } pulse_cnt_e;
endpackage

// File: rtl/resync_cs_edge.sv
module resync_cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_rise
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_rise = cs_n & ~cs_q;
endmodule

// File: rtl/resync_wrap_cnt.sv
module resync_wrap_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         at_end
);
  localparam int unsigned XW = W + 1;

  logic [XW-1:0] next_ext;

  assign next_ext = {1'b0, count} + XW'(1);
  // Treat a count at or beyond the limit as the last step, so a lowered limit cannot strand the counter.
  assign at_end   = (next_ext >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (step) begin
      if (at_end)    count <= '0;
      else           count <= next_ext[W-1:0];
    end
  end
endmodule

// File: rtl/resync_strobe_gate.sv
module resync_strobe_gate
  import pll_resync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rearm,
  input  logic fire,
  output logic sync_o,
  output logic strobe_o
);
  pulse_cnt_e pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= PC_DONE;
      sync_o   <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      sync_o   <= fire;
      strobe_o <= fire && (pc == PC_ONE);
      if (!enable)                     pc <= PC_DONE;
      else if (rearm)                  pc <= PC_NONE;
      else if (fire && pc == PC_NONE)  pc <= PC_ONE;
      else if (fire && pc == PC_ONE)   pc <= PC_DONE;
    end
  end
endmodule

// File: rtl/pll_resync_timer.sv
module pll_resync_timer
  import pll_resync_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] clk_div,
  input  logic [MOD_W-1:0] modulus,
  input  logic             ext_mod,
  input  logic             cs_n,
  output logic             sync_pulse,
  output logic             resync_strobe,
  output logic [CNT_W-1:0] div_count
);
  localparam logic [MOD_W-1:0] MOD_CAP = MOD_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] eff_mod;
  logic             enable;
  logic             cs_rise;
  logic             restart;
  logic             inner_end;
  logic             outer_end;
  logic [CNT_W-1:0] outer_count;
  logic             fire;

  always_comb begin
    if (ext_mod && (modulus > MOD_CAP)) eff_mod = MOD_CAP[CNT_W-1:0];
    else                                eff_mod = modulus[CNT_W-1:0];
  end

  assign enable  = (mode_sel == TMR_RESYNC) && (clk_div != '0) && (eff_mod != '0);
  assign restart = !enable || cs_rise;

  resync_cs_edge u_edge (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cs_rise (cs_rise)
  );

  resync_wrap_cnt #(.W(CNT_W)) u_inner (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .clr    (restart),
    .step   (1'b1),
    .limit  (clk_div),
    .count  (div_count),
    .at_end (inner_end)
  );

  resync_wrap_cnt #(.W(CNT_W)) u_outer (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .clr    (restart),
    .step   (inner_end),
    .limit  (eff_mod),
    .count  (outer_count),
    .at_end (outer_end)
  );

  assign fire = !restart && inner_end && outer_end;

  resync_strobe_gate u_gate (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .enable   (enable),
    .rearm    (cs_rise && enable),
    .fire     (fire),
    .sync_o   (sync_pulse),
    .strobe_o (resync_strobe)
  );
endmodule

// File: rtl/pll_resync_timer_chk.sv
module pll_resync_timer_chk (
  input logic        clk_ref,
  input logic        rst_n,
  input logic [1:0]  mode_sel,
  input logic [11:0] clk_div,
  input logic        cs_n,
  input logic        sync_pulse,
  input logic        resync_strobe,
  input logic [11:0] div_count
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(mode_sel) != 2'b10) |-> (!sync_pulse && !resync_strobe)); // R1
  AST_ZERO_DIV_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(clk_div) == 12'd0) |-> (!sync_pulse && !resync_strobe)); // R8
  AST_STROBE_WITH_SYNC: assert property (@(posedge clk_ref) disable iff (!rst_n)
    resync_strobe |-> sync_pulse); // R5
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    resync_strobe |=> !resync_strobe); // R6
  AST_CS_RESTART: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($rose(cs_n) && mode_sel == 2'b10) |=> (div_count == 12'd0)); // R7
  AST_NO_STROBE_AT_CS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(cs_n) |=> !resync_strobe); // R6
endmodule

bind pll_resync_timer pll_resync_timer_chk u_chk (
  .clk_ref       (clk_ref),
  .rst_n         (rst_n),
  .mode_sel      (mode_sel),
  .clk_div       (clk_div),
  .cs_n          (cs_n),
  .sync_pulse    (sync_pulse),
  .resync_strobe (resync_strobe),
  .div_count     (div_count)
);

// File: tb/pll_resync_timer_bench.sv
`timescale 1ns/1ps
module pll_resync_timer_bench;
  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [11:0] clk_div = 12'd0;
  logic [15:0] modulus = 16'd0;
  logic        ext_mod = 1'b0;
  logic        cs_n = 1'b1;
  logic        sync_pulse;
  logic        resync_strobe;
  logic [11:0] div_count;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int e0 = 0;
  int sync_seen = 0;
  int strobe_seen = 0;
  int sync_q[$];
  string sync_tag[$];
  int strobe_q[$];
  string strobe_tag[$];

  always #5 clk_ref = ~clk_ref;
  always @(posedge clk_ref) cyc <= cyc + 1;

  pll_resync_timer u_pll_resync_timer (
    .clk_ref(clk_ref), .rst_n(rst_n), .mode_sel(mode_sel), .clk_div(clk_div),
    .modulus(modulus), .ext_mod(ext_mod), .cs_n(cs_n), .sync_pulse(sync_pulse),
    .resync_strobe(resync_strobe), .div_count(div_count));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compare produced pulses with the scoreboard queues.
  always @(negedge clk_ref) if (rst_n) begin
    while (sync_q.size() > 0 && sync_q[0] < cyc) begin
      check(1'b0, {sync_tag[0], " missed sync"}, 0, sync_q[0]);
      void'(sync_q.pop_front()); void'(sync_tag.pop_front());
    end
    while (strobe_q.size() > 0 && strobe_q[0] < cyc) begin
      check(1'b0, {strobe_tag[0], " missed strobe"}, 0, strobe_q[0]);
      void'(strobe_q.pop_front()); void'(strobe_tag.pop_front());
    end
    if (sync_pulse) begin
      sync_seen++;
      if (sync_q.size() > 0 && sync_q[0] == cyc) begin
        check(1'b1, sync_tag[0], cyc, cyc);
        void'(sync_q.pop_front()); void'(sync_tag.pop_front());
      end else check(1'b0, "R2 unexpected sync", cyc, -1);
    end
    if (resync_strobe) begin
      strobe_seen++;
      if (strobe_q.size() > 0 && strobe_q[0] == cyc) begin
        check(1'b1, strobe_tag[0], cyc, cyc);
        void'(strobe_q.pop_front()); void'(strobe_tag.pop_front());
      end else check(1'b0, "R6 unexpected strobe", cyc, -1);
    end
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk_ref);
  endtask

  // Driver: quiet the timer, load settings, end a write with a chip-select rise.
  task automatic start(input logic [1:0] m, input int d, input int md, input bit ext);
    @(negedge clk_ref);
    mode_sel = 2'b00;
    clk_div = 12'(d); modulus = 16'(md); ext_mod = ext;
    cs_n = 1'b0;
    repeat (2) @(negedge clk_ref);
    mode_sel = m;
    cs_n = 1'b1;
    e0 = cyc + 1;
  endtask

  task automatic cs_again();
    cs_n = 1'b0;
    repeat (2) @(negedge clk_ref);
    cs_n = 1'b1;
    e0 = cyc + 1;
  endtask

  task automatic expect_pulses(input int per, input int first_n, input int last_n, input bool_strobe, input string tag);
    for (int n = first_n; n <= last_n; n++) begin
      sync_q.push_back(e0 + n * per); sync_tag.push_back(tag);
      if (n == 2 && bool_strobe != 0) begin
        strobe_q.push_back(e0 + n * per); strobe_tag.push_back({tag, " R5 strobe"});
      end
    end
  endtask

  task automatic stop_after(input int t);
    wait_cyc(t);
    mode_sel = 2'b00;
    repeat (3) @(negedge clk_ref);
  endtask

  task automatic quiet_run(input logic [1:0] m, input int d, input int md, input string tag);
    int s0, t0;
    start(m, d, md, 1'b0);
    s0 = sync_seen; t0 = strobe_seen;
    repeat (200) @(negedge clk_ref);
    check(sync_seen == s0, {tag, " no sync"}, sync_seen - s0, 0);
    check(strobe_seen == t0, {tag, " no strobe"}, strobe_seen - t0, 0);
    stop_after(cyc);
  endtask

  initial begin
    repeat (3) @(negedge clk_ref);
    check(!sync_pulse && !resync_strobe && div_count == 0, "R10 reset outputs",
          {sync_pulse, resync_strobe} + div_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_ref);

    // R2 R5 R6 R9: D=3, M=4, period 12; third pulse brings no strobe.
    start(2'b10, 3, 4, 1'b0);
    expect_pulses(12, 1, 3, 1, "R2 base");
    wait_cyc(e0);
    check(div_count == 0, "R9 count after restart", div_count, 0);
    wait_cyc(e0 + 2);
    check(div_count == 2, "R9 count climbs", div_count, 2);
    wait_cyc(e0 + 3);
    check(div_count == 0, "R9 count wraps", div_count, 0);
    stop_after(e0 + 3 * 12 + 1);

    // R3: upper modulus bits ignored in normal mode, 0x1005 -> 5, D=2 -> period 10.
    start(2'b10, 2, 16'h1005, 1'b0);
    expect_pulses(10, 1, 3, 1, "R3 truncated modulus");
    stop_after(e0 + 3 * 10 + 1);

    // R4: extended mode below the cap, 700*2 = 1400.
    start(2'b10, 2, 700, 1'b1);
    expect_pulses(1400, 1, 2, 1, "R4 ext small");
    stop_after(e0 + 2 * 1400 + 1);

    // R4: extended mode clamps 5000 to 4095, D=1.
    start(2'b10, 1, 5000, 1'b1);
    expect_pulses(4095, 1, 2, 1, "R4 ext clamp");
    stop_after(e0 + 2 * 4095 + 1);

    // R7: second write ends mid-period; timing restarts, pending strobe moves.
    start(2'b10, 5, 4, 1'b0);
    expect_pulses(20, 1, 1, 0, "R7 before rewrite");
    wait_cyc(e0 + 30);
    cs_again();
    expect_pulses(20, 1, 3, 1, "R7 after rewrite");
    stop_after(e0 + 3 * 20 + 1);

    // R1 / R8: disabled settings stay quiet.
    quiet_run(2'b11, 3, 4, "R1 mode 11");
    quiet_run(2'b01, 3, 4, "R1 mode 01");
    quiet_run(2'b10, 0, 4, "R8 div zero");
    quiet_run(2'b10, 3, 16'h1000, "R8 modulus zero");

    repeat (5) @(negedge clk_ref);
    check(sync_q.size() == 0 && strobe_q.size() == 0, "R2 scoreboard drained",
          sync_q.size() + strobe_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    bad++; total++;
    $display("FAIL watchdog R2 actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule